// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank, 32-bit DDR SDRAM and owns the command pins from reset until the memory is ready for normal traffic. After reset it keeps clock enable low and deselects the device. It counts a stable-clock interval derived from a clock-frequency parameter, then raises clock enable. It then issues a fixed series of commands: precharge-all, an extended mode register write that enables the DLL, a mode register write with DLL reset, a second precharge-all, two auto-refreshes, and a final mode register write with DLL reset cleared.

Each command is followed by a parameterised minimum gap, counted in clock cycles, in which only NOPs are driven. After the final write, the block waits until the DLL has had a programmable number of cycles since its reset. It then raises `init_done`, which stays high until the next reset. A normal controller takes over the pins once it sees `init_done`. Periodic refresh, data paths and strobe capture belong to that controller.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, and for as long as `cke` is low, `cke`=0 and `cs_n`=1 (device deselected); `init_done`=0 during reset.
- R2: `cke` goes high at the STABLE_CYC-th rising edge, counting from the first edge that samples `rst_n` high as edge 1, where STABLE_CYC = CLK_MHZ*STABLE_US. `cke` does not fall again without a reset.
- R3: Command encodings on {`cs_n`,`ras_n`,`cas_n`,`we_n`} are as follows. NOP is 0111. Precharge-all is 0010 with `addr[10]`=1. Auto-refresh is 0001. A mode write is 0000, with `ba`=2'b01 for the extended register and `ba`=2'b00 for the main register.
- R4: The commands appear in this order: precharge-all, extended write, main write with DLL reset, precharge-all, refresh, refresh, main write without DLL reset. Exactly these seven commands appear, and a NOP is driven in every other cycle after `cke` rises.
- R5: The extended write carries `addr`=EMR_VAL (default 0: DLL enabled, bit 0 low) on all address bits.
- R6: A main write carries these fields: `addr[2:0]`=BURST_CODE, `addr[3]`=BURST_INTERLEAVE, `addr[6:4]`=CAS_LAT (default 3), and all other bits 0. The exception is `addr[8]`, which is 1 on the first main write and 0 on the last.
- R7: The first precharge follows the `cke` rise by GAP_CKE cycles. Each command after a precharge follows it by GAP_RP cycles. Each command after a mode write follows it by GAP_MRD cycles. Each command after a refresh follows it by GAP_RFC cycles (default 17).
- R8: `init_done` is 0 until, and first becomes 1, exactly LOCK_CYC cycles after the DLL-reset mode write (when that is later than GAP_MRD after the final write).
- R9: Once high, `init_done` stays high until reset. During that time the outputs show `cke`=1 and NOP.
- R10: A reset mid-sequence drops `cke` and `init_done` at once and restarts the whole sequence from the stable-clock wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, same as the memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects which mode register is written |
| addr | output | ADDR_W | Address bus; mode field values and precharge-all bit |
| init_done | output | 1 | High once the memory is ready, held until reset |

## Verification
The only inputs are the clock and a synchronous reset. The assertions therefore assume that the clock runs without gaps and that `rst_n` changes only between edges. Under that assumption, every command and gap is a function of the parameters alone. The bench drives `rst_n` on falling edges and includes one reset asserted in the middle of a sequence. It shrinks the stable-clock interval through the parameters so that a full run fits well inside the cycle budget, and keeps the default refresh gap and DLL lock count.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int CLK_MHZ          = 250,
  parameter int STABLE_US        = 200,
  parameter int GAP_CKE          = 2,
  parameter int GAP_RP           = 4,
  parameter int GAP_MRD          = 2,
  parameter int GAP_RFC          = 17,
  parameter int LOCK_CYC         = 200,
  parameter int CAS_LAT          = 3,
  parameter int BURST_CODE       = 2,
  parameter int BURST_INTERLEAVE = 0,
  parameter int ADDR_W           = 12,
  parameter int EMR_VAL          = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int CW = $clog2(STABLE_CYC + GAP_CKE + GAP_RP + GAP_MRD + GAP_RFC + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam logic [ADDR_W-1:0] MR_RUN =
    ADDR_W'((CAS_LAT << 4) | (BURST_INTERLEAVE << 3) | BURST_CODE);
  localparam logic [ADDR_W-1:0] MR_DLLRST = MR_RUN | ADDR_W'(1 << 8);
  localparam logic [ADDR_W-1:0] EMR_WORD  = ADDR_W'(EMR_VAL);

  typedef enum logic [1:0] {HOLD, RUN, LOCK, DONE} st_t;

  st_t           st;
  logic [2:0]    step;
  logic [CW-1:0] cnt, gap;
  logic [LW-1:0] lk;

  wire fire = (st == RUN) && (cnt == '0);

  always_comb begin
    case (step)
      3'd0:          gap = CW'(GAP_CKE);
      3'd1, 3'd4:    gap = CW'(GAP_RP);
      3'd5, 3'd6:    gap = CW'(GAP_RFC);
      default:       gap = CW'(GAP_MRD);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= HOLD;
      cnt  <= CW'(STABLE_CYC - 1);
      step <= '0;
    end else begin
      case (st)
        HOLD: if (cnt == '0) st <= RUN; else cnt <= cnt - 1'b1;
        RUN: begin
          if (fire) begin
            cnt  <= gap - 1'b1;
            step <= step + 1'b1;
            if (step == 3'd7) st <= LOCK;
          end else cnt <= cnt - 1'b1;
        end
        LOCK: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (lk >= LW'(LOCK_CYC - 1)) st <= DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lk <= '0;
    else if (fire && step == 3'd3) lk <= LW'(1);
    else if (lk != '0 && lk != LW'(LOCK_CYC)) lk <= lk + 1'b1;
  end

  assign cke       = (st != HOLD);
  assign init_done = (st == DONE);

  always_comb begin
    cs_n  = !cke;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ba    = 2'b00;
    addr  = '0;
    if (fire) begin
      case (step)
        3'd1, 3'd4: begin ras_n = 1'b0; we_n = 1'b0; addr[10] = 1'b1; end
        3'd2: begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; ba = 2'b01; addr = EMR_WORD; end
        3'd3: begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; addr = MR_DLLRST; end
        3'd5, 3'd6: begin ras_n = 1'b0; cas_n = 1'b0; end
        3'd7: begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; addr = MR_RUN; end
        default: ;
      endcase
    end
  end

  a_r1_deselect_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cs_n);
  a_r2_cke_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  a_r3_precharge_all_a10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr[10]);
  a_r3_mode_write_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !cas_n && !we_n) |-> (ba[1] == 1'b0));
  a_r8_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (lk >= LW'(LOCK_CYC - 1)));
  a_r9_done_latches: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cke && !cs_n && ras_n && cas_n && we_n));
endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;
  localparam int CLK_MHZ = 1, STABLE_US = 30, GAP_CKE = 2, GAP_RP = 3, GAP_MRD = 2;
  localparam int GAP_RFC = 17, LOCK_CYC = 200, AW = 12;
  localparam int S = CLK_MHZ * STABLE_US;

  logic clk = 0, rst_n = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [AW-1:0] addr;
  int errors = 0, checks = 0;
  int ev_k[8], ev_code[8], ev_ba[8], ev_addr[8];
  int n_ev, cke_k, done_k, stray;

  always #2.5 clk = ~clk;

  ddr_init_seq #(.CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .GAP_CKE(GAP_CKE),
    .GAP_RP(GAP_RP), .GAP_MRD(GAP_MRD), .GAP_RFC(GAP_RFC), .LOCK_CYC(LOCK_CYC),
    .ADDR_W(AW)) uut (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int code();
    return {28'd0, cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic t_reset();
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(cke == 0, "R1 cke in reset", cke, 0);
    chk(cs_n == 1, "R1 cs_n in reset", cs_n, 1);
    chk(init_done == 0, "R1 init_done in reset", init_done, 0);
  endtask

  task automatic run_log(input int kmax);
    n_ev = 0; cke_k = -1; done_k = -1; stray = 0;
    rst_n = 1;
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      if (cke && cke_k < 0) cke_k = k;
      if (!cke && !cs_n) stray++;
      if (init_done && done_k < 0) done_k = k;
      if (cke && code() != 7) begin
        if (n_ev < 8) begin
          ev_k[n_ev] = k; ev_code[n_ev] = code(); ev_ba[n_ev] = ba; ev_addr[n_ev] = addr;
        end
        n_ev++;
      end else if (cke && cs_n) stray++;
    end
  endtask

  task automatic t_sequence();
    int exp_code[7] = '{2, 0, 0, 2, 1, 1, 0};
    int exp_ba[7]   = '{0, 1, 0, 0, 0, 0, 0};
    int exp_gap[7]  = '{GAP_CKE, GAP_RP, GAP_MRD, GAP_MRD, GAP_RP, GAP_RFC, GAP_RFC};
    int mr_run;
    mr_run = (3 << 4) | 2;
    run_log(S + 300);
    chk(stray == 0, "R4 NOP/deselect elsewhere", stray, 0);
    chk(cke_k == S, "R2 cke rise edge", cke_k, S);
    chk(n_ev == 7, "R4 command count", n_ev, 7);
    for (int i = 0; i < 7; i++) begin
      chk(ev_code[i] == exp_code[i], $sformatf("R3 R4 code of cmd %0d", i), ev_code[i], exp_code[i]);
      chk(ev_ba[i] == exp_ba[i], $sformatf("R3 bank of cmd %0d", i), ev_ba[i], exp_ba[i]);
      chk(ev_k[i] - (i == 0 ? cke_k : ev_k[i-1]) == exp_gap[i],
          $sformatf("R7 gap before cmd %0d", i), ev_k[i] - (i == 0 ? cke_k : ev_k[i-1]), exp_gap[i]);
    end
    chk(ev_addr[0][10] == 1 && ev_addr[3][10] == 1, "R3 precharge A10", ev_addr[0], 1024);
    chk(ev_addr[1] == 0, "R5 extended word", ev_addr[1], 0);
    chk(ev_addr[2] == (mr_run | 256), "R6 DLL reset word", ev_addr[2], mr_run | 256);
    chk(ev_addr[6] == mr_run, "R6 final mode word", ev_addr[6], mr_run);
    chk(done_k == ev_k[2] + LOCK_CYC, "R8 done edge", done_k, ev_k[2] + LOCK_CYC);
  endtask

  task automatic t_after_done();
    int bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!init_done || !cke || code() != 7) bad++;
    end
    chk(bad == 0, "R9 done held with NOP", bad, 0);
  endtask

  task automatic t_midreset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (S + 10) @(negedge clk);
    chk(cke == 1, "R10 running before reset", cke, 1);
    rst_n = 0;
    @(negedge clk);
    chk(cke == 0 && init_done == 0, "R10 reset drops cke", cke, 0);
    run_log(S + 20);
    chk(cke_k == S, "R10 restart cke edge", cke_k, S);
    chk(n_ev >= 1 && ev_k[0] == S + GAP_CKE && ev_code[0] == 2, "R10 restart first command",
        ev_k[0], S + GAP_CKE);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_after_done();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule